// File: doc/BRIEF.md
# Idle-Driven Link Framing Injector

This block sits in front of a word encoder on a simple point-to-point link that does not follow a standard framing protocol. The host has a single level input that marks idle time. It does not have to multiplex ordered-set controls into its data path. The block holds the input registers for the ordered-set flag and the full data word. While the idle input is high it overrides them, so the encoder sees a fixed sequence of delimiter and idle words. It also checks byte parity on the host words that it accepts.

When the idle input rises, the block emits one abort end-of-frame delimiter, then idle ordered sets for as long as the input stays high. The abort delimiter restores running disparity, which the injected idles do not. If CRC generation is selected, the first idle-high cycle is first given over to a CRC slot that the downstream CRC controller fills in. Data may resume on the first cycle the idle input drops, with no start-of-frame. The idle word just before it serves to reinitialise the CRC. A CRC slot always runs into its abort delimiter, even if the idle input has dropped by then. While this happens, a ready output stalls the host for one cycle.

Top module: `ifj_idle_injector`

## Requirements
- R1: During and after reset, `os_o`=1, the top byte of `data_o` equals IDLE_CODE, the lower bytes are zero, `crc_slot_o`=0, `par_err_o`=0 and `host_rdy_o`=1.
- R2: When a host word is accepted (idle input low, no pending CRC slot), `os_o` and `data_o` equal `host_os_i` and `host_data_i` from the clock edge where the word was sampled.
- R3: With `crc_gen_i` low, the first idle-high cycle after data loads an abort: `os_o`=1, the top byte is ABORT_CODE and the lower bytes are zero.
- R4: Every further cycle with the idle input held high loads an idle word: `os_o`=1, the top byte is IDLE_CODE and the lower bytes are zero.
- R5: With `crc_gen_i` high, the first idle-high cycle after data loads a CRC slot (`crc_slot_o`=1, `os_o`=0, `data_o` zero). The next cycle loads the abort, and idles follow.
- R6: Parity is odd per byte: bit i of `host_par_i` covers `host_data_i[8i+7:8i]`, and each byte together with its bit must hold an odd number of ones. With `par_en_i` high, an accepted word that breaks this sets `par_err_o` in the cycle its data appears.
- R7: While the idle input is high, and for a stalled word, host data, flag and parity are ignored and `par_err_o` stays 0.
- R8: If the idle input drops while a CRC slot is loaded, the abort is still loaded next and `host_rdy_o` is 0 for that cycle. The word offered then is not taken.
- R9: After an abort or an idle word, the first cycle with the idle input low accepts the host word directly.
- R10: `crc_gen_i` is only sampled on the first idle-high cycle after data. Changing it later in an idle run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | High marks idle time on the link |
| crc_gen_i | input | 1 | High selects a CRC slot before the abort |
| par_en_i | input | 1 | High enables host parity checking |
| host_os_i | input | 1 | Ordered-set flag from host (normally tied low) |
| host_data_i | input | 32 | Host data word |
| host_par_i | input | 4 | Odd parity bit per host byte |
| host_rdy_o | output | 1 | Low when the offered host word is not accepted |
| os_o | output | 1 | Registered ordered-set flag to the encoder |
| data_o | output | 32 | Registered word to the encoder |
| crc_slot_o | output | 1 | Registered marker that this word slot carries CRC |
| par_err_o | output | 1 | Registered parity error for the accepted word |

## Verification
The hardest case to reach is a stall. It needs a data word, then exactly one idle-high cycle with CRC generation on, and then the idle input dropping at once while a valid-looking word with deliberately bad parity is offered. The bench builds this edge by edge. It shows that the abort still comes out and that the ready signal drops for that cycle. It also shows that neither the stalled word nor its parity error ever reaches the outputs, and that re-offering the word afterwards passes it through.

// File: rtl/ifj_pkg.sv
package ifj_pkg;
  typedef enum logic [1:0] {
    ST_PASS     = 2'd0,
    ST_CRC_SLOT = 2'd1,
    ST_ABORT    = 2'd2,
    ST_IDLE     = 2'd3
  } ifj_state_e;
endpackage

// File: rtl/ifj_parity_chk.sv
module ifj_parity_chk #(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic [NBYTES*BYTE_W-1:0] data_i,
  input  logic [NBYTES-1:0]        par_i,
  input  logic                     en_i,
  output logic                     err_o
);
  logic [NBYTES-1:0] byte_bad;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    // odd parity: byte plus its bit must carry an odd count of ones
    assign byte_bad[g] = ~(^{data_i[g*BYTE_W +: BYTE_W], par_i[g]});
  end

  assign err_o = en_i & (|byte_bad);
endmodule

// File: rtl/ifj_seq.sv
module ifj_seq
  import ifj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_i,
  input  logic       crc_gen_i,
  output ifj_state_e cur_o,
  output ifj_state_e nxt_o,
  output logic       host_rdy_o
);
  ifj_state_e cur_q, nxt_d;

  always_comb begin
    nxt_d = cur_q;
    unique case (cur_q)
      ST_PASS:     nxt_d = idle_i ? (crc_gen_i ? ST_CRC_SLOT : ST_ABORT) : ST_PASS;
      ST_CRC_SLOT: nxt_d = ST_ABORT;
      ST_ABORT:    nxt_d = idle_i ? ST_IDLE : ST_PASS;
      ST_IDLE:     nxt_d = idle_i ? ST_IDLE : ST_PASS;
      default:     nxt_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= ST_IDLE;
    else        cur_q <= nxt_d;
  end

  assign cur_o      = cur_q;
  assign nxt_o      = nxt_d;
  assign host_rdy_o = (cur_q != ST_CRC_SLOT);

  AST_DATA_TO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_PASS && idle_i && !crc_gen_i) |=> (cur_q == ST_ABORT)); // R3
  AST_DATA_TO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_PASS && idle_i && crc_gen_i) |=> (cur_q == ST_CRC_SLOT)); // R5
  AST_SLOT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_CRC_SLOT) |=> (cur_q == ST_ABORT)); // R8
  AST_LOW_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != ST_CRC_SLOT && !idle_i) |=> (cur_q == ST_PASS)); // R9
endmodule

// File: rtl/ifj_word_reg.sv
module ifj_word_reg
  import ifj_pkg::*;
#(
  parameter int                 NBYTES     = 4,
  parameter int                 BYTE_W     = 8,
  parameter logic [BYTE_W-1:0]  ABORT_CODE = 8'h95,
  parameter logic [BYTE_W-1:0]  IDLE_CODE  = 8'hBC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ifj_state_e               cur_i,
  input  ifj_state_e               nxt_i,
  input  logic                     host_os_i,
  input  logic [NBYTES*BYTE_W-1:0] host_data_i,
  input  logic                     perr_i,
  output logic                     os_o,
  output logic [NBYTES*BYTE_W-1:0] data_o,
  output logic                     crc_slot_o,
  output logic                     par_err_o
);
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int LOW_W  = DATA_W - BYTE_W;

  logic              os_q, os_d;
  logic [BYTE_W-1:0] top_q, top_d;
  logic [LOW_W-1:0]  low_q, low_d;
  logic              low_en;
  logic              slot_q, slot_d;
  logic              perr_q, perr_d;

  always_comb begin
    os_d   = 1'b1;
    top_d  = IDLE_CODE;
    low_d  = '0;
    slot_d = 1'b0;
    perr_d = 1'b0;
    unique case (nxt_i)
      ST_PASS: begin
        os_d   = host_os_i;
        top_d  = host_data_i[DATA_W-1 -: BYTE_W];
        low_d  = host_data_i[LOW_W-1:0];
        perr_d = perr_i;
      end
      ST_CRC_SLOT: begin
        os_d   = 1'b0;
        top_d  = '0;
        slot_d = 1'b1;
      end
      ST_ABORT: top_d = ABORT_CODE;
      default:  top_d = IDLE_CODE;
    endcase
  end

  // lower bytes only change when data is taken or when leaving data
  assign low_en = (nxt_i == ST_PASS) || (cur_i == ST_PASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_q   <= 1'b1;
      top_q  <= IDLE_CODE;
      slot_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      os_q   <= os_d;
      top_q  <= top_d;
      slot_q <= slot_d;
      perr_q <= perr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_q <= '0;
    else if (low_en) low_q <= low_d;
  end

  assign os_o       = os_q;
  assign data_o     = {top_q, low_q};
  assign crc_slot_o = slot_q;
  assign par_err_o  = perr_q;

  AST_SLOT_THEN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q |=> (os_q && top_q == ABORT_CODE)); // R5
  AST_OVERRIDE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_i != ST_PASS) |-> (low_q == '0)); // R4
endmodule

// File: rtl/ifj_idle_injector.sv
module ifj_idle_injector
  import ifj_pkg::*;
#(
  parameter int                NBYTES     = 4,
  parameter int                BYTE_W     = 8,
  parameter logic [BYTE_W-1:0] ABORT_CODE = 8'h95,
  parameter logic [BYTE_W-1:0] IDLE_CODE  = 8'hBC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     idle_i,
  input  logic                     crc_gen_i,
  input  logic                     par_en_i,
  input  logic                     host_os_i,
  input  logic [NBYTES*BYTE_W-1:0] host_data_i,
  input  logic [NBYTES-1:0]        host_par_i,
  output logic                     host_rdy_o,
  output logic                     os_o,
  output logic [NBYTES*BYTE_W-1:0] data_o,
  output logic                     crc_slot_o,
  output logic                     par_err_o
);
  ifj_state_e cur_st, nxt_st;
  logic       perr_raw;

  ifj_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_i     (idle_i),
    .crc_gen_i  (crc_gen_i),
    .cur_o      (cur_st),
    .nxt_o      (nxt_st),
    .host_rdy_o (host_rdy_o)
  );

  ifj_parity_chk #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_par (
    .data_i (host_data_i),
    .par_i  (host_par_i),
    .en_i   (par_en_i),
    .err_o  (perr_raw)
  );

  ifj_word_reg #(
    .NBYTES(NBYTES), .BYTE_W(BYTE_W),
    .ABORT_CODE(ABORT_CODE), .IDLE_CODE(IDLE_CODE)
  ) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_i       (cur_st),
    .nxt_i       (nxt_st),
    .host_os_i   (host_os_i),
    .host_data_i (host_data_i),
    .perr_i      (perr_raw),
    .os_o        (os_o),
    .data_o      (data_o),
    .crc_slot_o  (crc_slot_o),
    .par_err_o   (par_err_o)
  );

  AST_IDLE_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle_i) |-> !par_err_o); // R7
  AST_STALL_MEANS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdy_o |-> crc_slot_o); // R8
endmodule

// File: tb/sim_ifj_idle_injector.sv
module sim_ifj_idle_injector;
  localparam int CLK_P = 10;
  localparam logic [7:0] AB = 8'h95;
  localparam logic [7:0] ID = 8'hBC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        idle_i, crc_gen_i, par_en_i, host_os_i;
  logic [31:0] host_data_i;
  logic [3:0]  host_par_i;
  logic        host_rdy_o, os_o, crc_slot_o, par_err_o;
  logic [31:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ifj_idle_injector u0 (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .crc_gen_i(crc_gen_i),
    .par_en_i(par_en_i), .host_os_i(host_os_i), .host_data_i(host_data_i),
    .host_par_i(host_par_i), .host_rdy_o(host_rdy_o), .os_o(os_o),
    .data_o(data_o), .crc_slot_o(crc_slot_o), .par_err_o(par_err_o)
  );

  function automatic logic [3:0] gpar(input logic [31:0] d);
    for (int i = 0; i < 4; i++) gpar[i] = ~(^d[i*8 +: 8]);
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive inputs on the falling edge, sample one unit after the rising edge
  task automatic cyc(input logic idl, input logic cg, input logic os,
                     input logic [31:0] d, input logic [3:0] p);
    @(negedge clk);
    idle_i = idl; crc_gen_i = cg; host_os_i = os; host_data_i = d; host_par_i = p;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 flag", {35'd0, os_o}, 36'd1);
    chk("R1 word", {4'd0, data_o}, {4'd0, ID, 24'd0});
    chk("R1 slot/perr/rdy", {33'd0, crc_slot_o, par_err_o, host_rdy_o}, 36'b001);
  endtask

  task automatic t_pass;
    cyc(0, 0, 0, 32'h1234_5678, gpar(32'h1234_5678));
    chk("R9 word", {4'd0, data_o}, {4'd0, 32'h1234_5678});
    chk("R2 perr", {35'd0, par_err_o}, 36'd0);
    cyc(0, 0, 1, 32'hCAFE_0001, gpar(32'hCAFE_0001));
    chk("R2 flag+word", {3'd0, os_o, data_o}, {3'd0, 1'b1, 32'hCAFE_0001});
    cyc(0, 0, 0, 32'h0F0F_00FF, gpar(32'h0F0F_00FF) ^ 4'b0100);
    chk("R6 bad byte2", {35'd0, par_err_o}, 36'd1);
  endtask

  task automatic t_no_crc;
    cyc(1, 0, 1, 32'hDEAD_BEEF, 4'h0);
    chk("R3 abort", {3'd0, os_o, data_o}, {3'd0, 1'b1, AB, 24'd0});
    chk("R7 perr idle", {35'd0, par_err_o}, 36'd0);
    cyc(1, 1, 0, 32'hFFFF_FFFF, 4'h0);
    chk("R4 idle1", {3'd0, os_o, data_o}, {3'd0, 1'b1, ID, 24'd0});
    chk("R10 no slot", {35'd0, crc_slot_o}, 36'd0);
    cyc(1, 0, 0, 32'h1111_1111, 4'h0);
    chk("R4 idle2", {3'd0, os_o, data_o}, {3'd0, 1'b1, ID, 24'd0});
    cyc(0, 0, 0, 32'hA5A5_5A5A, gpar(32'hA5A5_5A5A));
    chk("R9 resume", {3'd0, os_o, data_o}, {3'd0, 1'b0, 32'hA5A5_5A5A});
  endtask

  task automatic t_crc;
    cyc(1, 1, 0, 32'h7777_7777, 4'h0);
    chk("R5 slot", {2'd0, crc_slot_o, os_o, data_o}, {2'd0, 1'b1, 1'b0, 32'd0});
    cyc(1, 1, 0, 32'h7777_7777, 4'h0);
    chk("R5 abort", {2'd0, crc_slot_o, os_o, data_o}, {2'd0, 1'b0, 1'b1, AB, 24'd0});
    cyc(1, 1, 0, 32'h7777_7777, 4'h0);
    chk("R5 idle", {3'd0, os_o, data_o}, {3'd0, 1'b1, ID, 24'd0});
    cyc(0, 1, 0, 32'h0102_0304, gpar(32'h0102_0304));
    chk("R9 after crc", {4'd0, data_o}, {4'd0, 32'h0102_0304});
  endtask

  task automatic t_stall;
    cyc(1, 1, 0, 32'h0, 4'h0);
    chk("R8 slot rdy", {34'd0, crc_slot_o, host_rdy_o}, 36'b10);
    cyc(0, 1, 1, 32'h5555_AAAA, 4'h0);
    chk("R8 abort kept", {3'd0, os_o, data_o}, {3'd0, 1'b1, AB, 24'd0});
    chk("R7 stalled perr", {35'd0, par_err_o}, 36'd0);
    chk("R8 rdy back", {35'd0, host_rdy_o}, 36'd1);
    cyc(0, 1, 0, 32'h5555_AAAA, gpar(32'h5555_AAAA));
    chk("R8 word taken", {3'd0, os_o, data_o}, {3'd0, 1'b0, 32'h5555_AAAA});
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle_i = 1'b1; crc_gen_i = 1'b0; par_en_i = 1'b1;
    host_os_i = 1'b0; host_data_i = '0; host_par_i = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_pass();
    t_no_crc();
    t_crc();
    t_stall();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule